// File: doc/BRIEF.md
# Log-Sine Waveform Operator Output

This block converts an operator's phase and its attenuation into a signed audio sample. It works in the logarithmic domain. A quarter-wave log-sine table gives the log magnitude for the phase. The attenuation is added to that log value, and an exponential table turns the sum back into a linear magnitude. A sign is then applied by bit inversion.

Eight waveform shapes come from the same two tables. The phase is folded by quadrant, its index is doubled, or the table value is replaced by a fixed log value. A mode input limits the shape selection to the first four shapes.

The block sits between a phase accumulator and an envelope generator on one side, and a channel mixer on the other. It holds no state except an optional output register. Both tables are computed from closed formulas while the design elaborates.

Top module: `lsw_operator`

## Requirements
- R1: With `REG_OUT=1` the sample presents the result for the inputs sampled at the previous rising clock edge. While `rst` is high at a rising edge, the sample is cleared to 0.
- R2: The phase is 10 bits, bit 9 being the most significant. The log-sine table has 256 entries, and entry i is round(-log2(sin((i+0.5)·π/512))·256). For the sine-based shapes the index is phase[7:0] when phase[8] is 0 and the bitwise inverse of phase[7:0] when phase[8] is 1, so phases p and p^0x1FF give the same magnitude.
- R3: The log level is the log value plus attenuation·8, limited to 0x1FFF. The exp table entry j is round((2^(j/256)-1)·1024). The magnitude is (((exp[~level[7:0]] | 0x400) << 1) >> level[12:8]).
- R4: When a shape marks the sample negative, the 16-bit output is the bitwise inverse of the zero-extended magnitude, not its two's complement.
- R5: Select code 0 is a full sine that is negative when phase[9] is 1. Code 1 is the same sine with the negative half replaced by log value 0x1000, which gives a zero output. Code 2 is the sine with no sign. Code 3 uses the index phase[7:0] with no sign, and gives log value 0x1000 when phase[8] is 1.
- R6: Codes 4 and 5 give log value 0x1000 when phase[9] is 1. Otherwise their index is {phase[6:0],0}, or {~phase[6:0],0} when phase[7] is 1. Code 4 is negative when phase[9:8] equals 01, and code 5 is never negative.
- R7: Code 6 has log value 0 and is negative when phase[9] is 1. With attenuation 0 it gives 0x0FF4 or 0xF00B. Code 7 has log value phase[8:0]·8 when phase[9] is 0. When phase[9] is 1 its log value is (~phase[8:0])·8 and it is negative.
- R8: When `ext_mode` is 0 only wave_sel[1:0] is used, so codes 4 to 7 act as codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 10 | Operator phase, one full cycle over 1024 steps |
| atten | input | 9 | Attenuation in log units of 1/32 of an octave |
| wave_sel | input | 3 | Waveform shape code 0 to 7 |
| ext_mode | input | 1 | 1 allows all eight shapes, 0 limits the selection to codes 0 to 3 |
| sample | output | 16 | Signed output sample |

## Verification
The bench builds the block with its default `REG_OUT=1`, so every result appears one edge after its inputs. That latency and the reset clearing of the registered sample can both be observed.

All 1024 phases of every shape are swept at several attenuations, including 0 and the maximum. These sweeps cover every table entry, every fold boundary and the smallest nonzero magnitudes. A full attenuation sweep at a fixed phase exercises every exponent shift. Sweeps with `ext_mode` low confirm that the upper four codes fall back to the lower four.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    localparam int PHASE_W   = 10;
    localparam int ATT_W     = 9;
    localparam int IDX_W     = 8;
    localparam int TAB_N     = 1 << IDX_W;
    localparam int LOGSIN_W  = 12;
    localparam int EXP_W     = 10;
    localparam int LOG_W     = 13;
    localparam int SUM_W     = LOG_W + 1;
    localparam int SHIFT_W   = LOG_W - IDX_W;
    localparam int MAG_W     = EXP_W + 2;
    localparam int OUT_W     = 16;
    localparam int ATT_SHIFT = 3;

    localparam logic [LOG_W-1:0] LOG_SILENT = 13'h1000;
    localparam logic [LOG_W-1:0] LOG_LIMIT  = 13'h1FFF;

    localparam real PI_R = 3.14159265358979323846;

    typedef enum logic [2:0] {
        SHP_SINE    = 3'd0,
        SHP_HALF    = 3'd1,
        SHP_ABS     = 3'd2,
        SHP_QUARTER = 3'd3,
        SHP_ALT     = 3'd4,
        SHP_CAMEL   = 3'd5,
        SHP_SQUARE  = 3'd6,
        SHP_SAW     = 3'd7
    } shape_e;

    // Result of the phase folding step.
    typedef struct packed {
        logic              use_tab;   // take the log value from the log-sine table
        logic [IDX_W-1:0]  idx;       // table index when use_tab is set
        logic [LOG_W-1:0]  fixed_log; // log value when use_tab is clear
        logic              neg;       // output is inverted
    } fold_t;

    function automatic logic [LOGSIN_W*TAB_N-1:0] build_logsin();
        logic [LOGSIN_W*TAB_N-1:0] tab;
        real ang;
        real val;
        tab = '0;
        for (int i = 0; i < TAB_N; i++) begin
            ang = ($itor(i) + 0.5) * PI_R / 512.0;
            val = -($ln($sin(ang)) / $ln(2.0)) * 256.0;
            tab[i*LOGSIN_W +: LOGSIN_W] = LOGSIN_W'($rtoi(val + 0.5));
        end
        return tab;
    endfunction

    function automatic logic [EXP_W*TAB_N-1:0] build_exp();
        logic [EXP_W*TAB_N-1:0] tab;
        real val;
        tab = '0;
        for (int i = 0; i < TAB_N; i++) begin
            val = ($pow(2.0, $itor(i) / 256.0) - 1.0) * 1024.0;
            tab[i*EXP_W +: EXP_W] = EXP_W'($rtoi(val + 0.5));
        end
        return tab;
    endfunction

endpackage

// File: rtl/lsw_logsin_rom.sv
module lsw_logsin_rom
    import lsw_pkg::*;
(
    input  logic [IDX_W-1:0]    idx,
    output logic [LOGSIN_W-1:0] log_val
);
    localparam logic [LOGSIN_W*TAB_N-1:0] TAB = build_logsin();

    assign log_val = TAB[idx*LOGSIN_W +: LOGSIN_W];
endmodule

// File: rtl/lsw_shaper.sv
module lsw_shaper
    import lsw_pkg::*;
(
    input  logic [PHASE_W-1:0] phase,
    input  shape_e             shape,
    output fold_t              fold
);
    logic [IDX_W-1:0] idx_mirror;
    logic [IDX_W-1:0] idx_double;
    logic [LOG_W-1:0] saw_log;

    // Quarter mirror on bit 8, doubled index mirrored on bit 7.
    assign idx_mirror = phase[8] ? ~phase[7:0] : phase[7:0];
    assign idx_double = phase[7] ? {~phase[6:0], 1'b0} : {phase[6:0], 1'b0};
    assign saw_log    = phase[9] ? {1'b0, ~phase[8:0], 3'b000}
                                 : {1'b0,  phase[8:0], 3'b000};

    always_comb begin
        fold           = '0;
        fold.idx       = idx_mirror;
        fold.use_tab   = 1'b1;
        fold.fixed_log = LOG_SILENT;
        unique case (shape)
            SHP_SINE: begin
                fold.neg = phase[9];
            end
            SHP_HALF: begin
                fold.use_tab = ~phase[9];
            end
            SHP_ABS: begin
                fold.use_tab = 1'b1;
            end
            SHP_QUARTER: begin
                fold.idx     = phase[7:0];
                fold.use_tab = ~phase[8];
            end
            SHP_ALT: begin
                fold.idx     = idx_double;
                fold.use_tab = ~phase[9];
                fold.neg     = (phase[9:8] == 2'b01);
            end
            SHP_CAMEL: begin
                fold.idx     = idx_double;
                fold.use_tab = ~phase[9];
            end
            SHP_SQUARE: begin
                fold.use_tab   = 1'b0;
                fold.fixed_log = '0;
                fold.neg       = phase[9];
            end
            SHP_SAW: begin
                fold.use_tab   = 1'b0;
                fold.fixed_log = saw_log;
                fold.neg       = phase[9];
            end
            default: fold = '0;
        endcase
    end
endmodule

// File: rtl/lsw_exp_conv.sv
module lsw_exp_conv
    import lsw_pkg::*;
(
    input  logic [SUM_W-1:0] level_raw,
    output logic [MAG_W-1:0] mag
);
    localparam logic [EXP_W*TAB_N-1:0] TAB = build_exp();

    logic [LOG_W-1:0]   level;
    logic [IDX_W-1:0]   frac_idx;
    logic [EXP_W-1:0]   frac_val;
    logic [MAG_W-1:0]   mant;
    logic [SHIFT_W-1:0] shamt;

    // Saturate the log level before conversion.
    assign level    = level_raw[SUM_W-1] ? LOG_LIMIT : level_raw[LOG_W-1:0];
    assign frac_idx = ~level[IDX_W-1:0];
    assign frac_val = TAB[frac_idx*EXP_W +: EXP_W];
    assign mant     = {1'b1, frac_val, 1'b0};
    assign shamt    = level[LOG_W-1:IDX_W];
    assign mag      = mant >> shamt;
endmodule

// File: rtl/lsw_operator.sv
module lsw_operator
    import lsw_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [9:0]               phase,
    input  logic [8:0]               atten,
    input  logic [2:0]               wave_sel,
    input  logic                     ext_mode,
    output logic signed [15:0]       sample
);
    shape_e              shape;
    fold_t               fold;
    logic [LOGSIN_W-1:0] tab_log;
    logic [LOG_W-1:0]    base_log;
    logic [SUM_W-1:0]    level_sum;
    logic [MAG_W-1:0]    mag;
    logic [OUT_W-1:0]    mag_ext;
    logic [OUT_W-1:0]    result;

    // Restricted mode keeps only the two low select bits.
    assign shape = shape_e'(ext_mode ? wave_sel : {1'b0, wave_sel[1:0]});

    lsw_shaper u_shaper (
        .phase (phase),
        .shape (shape),
        .fold  (fold)
    );

    lsw_logsin_rom u_logsin (
        .idx     (fold.idx),
        .log_val (tab_log)
    );

    assign base_log  = fold.use_tab ? LOG_W'(tab_log) : fold.fixed_log;
    assign level_sum = SUM_W'(base_log) + (SUM_W'(atten) << ATT_SHIFT);

    lsw_exp_conv u_exp (
        .level_raw (level_sum),
        .mag       (mag)
    );

    assign mag_ext = OUT_W'(mag);
    assign result  = fold.neg ? ~mag_ext : mag_ext;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) sample <= '0;
                else     sample <= result;
            end

            assert_sign_R4: assert property (@(posedge clk) disable iff (rst)
                fold.neg |=> (sample[15:12] == 4'hF));

            assert_silent_half_R6: assert property (@(posedge clk) disable iff (rst)
                (ext_mode && wave_sel == 3'd5 && phase[9]) |=> (sample == 16'sd0));

            assert_abs_positive_R5: assert property (@(posedge clk) disable iff (rst)
                (wave_sel[1:0] == 2'd2 && (!ext_mode || !wave_sel[2])) |=> !sample[15]);

            assert_square_pos_R7: assert property (@(posedge clk) disable iff (rst)
                (ext_mode && wave_sel == 3'd6 && atten == 9'd0 && !phase[9])
                |=> (sample == 16'sh0FF4));

            assert_square_neg_R7: assert property (@(posedge clk) disable iff (rst)
                (ext_mode && wave_sel == 3'd6 && atten == 9'd0 && phase[9])
                |=> (sample == 16'shF00B));

            assert_mask_R8: assert property (@(posedge clk) disable iff (rst)
                (!ext_mode && wave_sel == 3'd6) |=> !sample[15]);
        end else begin : g_comb
            assign sample = result;
        end
    endgenerate
endmodule

// File: tb/lsw_operator_bench.sv
module lsw_operator_bench;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [9:0]        phase = '0;
    logic [8:0]        atten = '0;
    logic [2:0]        wave_sel = '0;
    logic              ext_mode = 1'b0;
    logic signed [15:0] sample;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    int ls_m [256];
    int ex_m [256];

    always #4 clk = ~clk;

    lsw_operator u_lsw_operator (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .atten    (atten),
        .wave_sel (wave_sel),
        .ext_mode (ext_mode),
        .sample   (sample)
    );

    function automatic int ref_out(int ph, int att, int sel, bit ext);
        int s, lg, lv, mag, ix;
        bit neg;
        s   = ext ? sel : (sel & 3);
        ph  = ph & 10'h3FF;
        neg = 0;
        ix  = ph[8] ? ((ph & 8'hFF) ^ 8'hFF) : (ph & 8'hFF);
        case (s)
            0: begin lg = ls_m[ix]; neg = ph[9]; end
            1: lg = ph[9] ? 32'h1000 : ls_m[ix];
            2: lg = ls_m[ix];
            3: lg = ph[8] ? 32'h1000 : ls_m[ph & 8'hFF];
            4, 5: begin
                if (ph[9]) lg = 32'h1000;
                else if (ph[7]) lg = ls_m[((ph ^ 8'hFF) << 1) & 8'hFF];
                else lg = ls_m[(ph << 1) & 8'hFF];
                if (s == 4) neg = (ph[9:8] == 2'b01);
            end
            6: begin lg = 0; neg = ph[9]; end
            default: begin
                if (ph[9]) begin neg = 1; lg = ((ph & 9'h1FF) ^ 9'h1FF) << 3; end
                else lg = ph << 3;
            end
        endcase
        lv = lg + att * 8;
        if (lv > 32'h1FFF) lv = 32'h1FFF;
        mag = ((ex_m[(lv & 8'hFF) ^ 8'hFF] | 32'h400) << 1) >> (lv >> 8);
        return neg ? ((~mag) & 16'hFFFF) : (mag & 16'hFFFF);
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at a falling edge, read one falling edge later (one register stage).
    task automatic apply(input int ph, input int att, input int sel, input bit ext,
                         output logic [15:0] got);
        phase    = 10'(ph);
        atten    = 9'(att);
        wave_sel = 3'(sel);
        ext_mode = ext;
        @(negedge clk);
        got = sample;
    endtask

    task automatic t_reset_R1();
        logic [15:0] g;
        rst = 1'b1;
        phase = 10'h080; atten = 9'd0; wave_sel = 3'd6; ext_mode = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset clears", sample, 16'h0000);
        rst = 1'b0;
        apply(10'h080, 0, 6, 1, g);
        chk("R1 one-edge latency", g, 16'h0FF4);
        apply(10'h280, 0, 6, 1, g);
        chk("R1 next sample", g, 16'hF00B);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid-run", sample, 16'h0000);
        rst = 1'b0;
    endtask

    task automatic t_sweep(input int sel, input bit ext, input string req);
        logic [15:0] g;
        int atts [4] = '{0, 9'h040, 9'h100, 9'h1FF};
        foreach (atts[k]) begin
            for (int p = 0; p < 1024; p++) begin
                apply(p, atts[k], sel, ext, g);
                chk(req, g, 16'(ref_out(p, atts[k], sel, ext)));
            end
        end
    endtask

    task automatic t_mirror_R2();
        logic [15:0] a, b;
        for (int p = 0; p < 512; p++) begin
            apply(p, 0, 2, 1, a);
            apply(p ^ 10'h1FF, 0, 2, 1, b);
            chk("R2 quarter mirror", a, b);
        end
    endtask

    task automatic t_sign_R4();
        logic [15:0] a, b;
        for (int p = 0; p < 512; p += 7) begin
            apply(p, 9'h020, 0, 1, a);
            apply(p | 10'h200, 9'h020, 0, 1, b);
            chk("R4 ones complement", b, ~a);
        end
    endtask

    task automatic t_atten_R3();
        logic [15:0] g;
        for (int a = 0; a < 512; a++) begin
            apply(10'h0C3, a, 0, 1, g);
            chk("R3 attenuation sweep", g, 16'(ref_out(10'h0C3, a, 0, 1)));
        end
        apply(10'h000, 9'h1FF, 1, 1, g);
        chk("R3 deep attenuation", g, 16'(ref_out(0, 9'h1FF, 1, 1)));
    endtask

    task automatic t_mask_R8();
        logic [15:0] a, b;
        for (int s = 4; s < 8; s++) begin
            for (int p = 0; p < 1024; p += 3) begin
                apply(p, 9'h010, s, 0, a);
                apply(p, 9'h010, s - 4, 1, b);
                chk("R8 restricted select", a, b);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            real v;
            v = -($ln($sin(($itor(i) + 0.5) * 3.14159265358979323846 / 512.0)) / $ln(2.0)) * 256.0;
            ls_m[i] = $rtoi(v + 0.5);
            v = ($pow(2.0, $itor(i) / 256.0) - 1.0) * 1024.0;
            ex_m[i] = $rtoi(v + 0.5);
        end
        @(negedge clk);
        t_reset_R1();
        t_sweep(0, 1, "R5 full sine");
        t_sweep(1, 1, "R5 half sine");
        t_sweep(2, 1, "R5 absolute sine");
        t_sweep(3, 1, "R5 quarter pulses");
        t_sweep(4, 1, "R6 alternating doubled");
        t_sweep(5, 1, "R6 camel doubled");
        t_sweep(6, 1, "R7 square");
        t_sweep(7, 1, "R7 log saw");
        t_sweep(6, 0, "R8 code 6 as code 2");
        t_mirror_R2();
        t_sign_R4();
        t_atten_R3();
        t_mask_R8();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule